// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

A watchdog timer for a chip whose software must prove it is alive. A bus-side register file, clocked by the system bus clock, feeds a counting core that runs on a slow tick clock (nominally 32 kHz). The core holds an up-counter. When the counter rolls over from all ones, the core raises a reset pulse and restarts the count from a software-chosen load value. Software holds the reset off by reloading the counter before it rolls over. It does this by writing a value to the trigger register that differs from the last one written there.

Software can start or stop the counter only through a pair of key words written back to back to the key register, so a single stray write cannot silence the watchdog. An optional prescaler slows the count by a power of two. Every writable register crosses into the slow domain through its own toggle handshake. While a crossing is still in flight, the matching bit of a status register stays set, and any further write to that register is dropped. Software therefore polls the status register before each write.

Top module: `kwdt_top`

## Requirements
- R1: After reset the status register reads 0, the control register reads 0, the trigger register reads 0, the load register reads the bitwise inverse of LOAD_GAP in CNT_W bits, and the counter is running.
- R2: The counter starts only when the key register receives 0xBBBB and then 0x4444 as two consecutive applied key writes (low 16 bits compared). Any other key word in between, or 0x4444 alone, leaves it stopped. A stopped counter holds its value.
- R3: The counter stops only when the key register receives 0xAAAA and then 0x5555 as two consecutive applied key writes. An intervening other key word cancels the stop.
- R4: While the counter is running with the prescaler off, it advances one step per slow clock. A rollover reloads it with the load value L, so reset pulses start every 2^CNT_W − L slow cycles.
- R5: Control bit 5 enables the prescaler and control bits 4:2 hold a ratio p. With bit 5 set the counter steps once every 2^p slow cycles. With bit 5 clear the ratio field has no effect.
- R6: A trigger write whose value differs from the stored trigger value reloads the counter with the load value. A trigger write of the same value has no effect.
- R7: Each reset pulse on `wdt_rst_o` stays high for exactly RST_CYC slow cycles.
- R8: Status bits track pending crossings: bit 0 control, bit 2 load, bit 3 trigger, bit 4 key; bit 1 reads 0. A bit is set in the bus cycle after an accepted write and clears only after the slow domain has applied that write.
- R9: A bus write to a register whose status bit is set is dropped; the register keeps its earlier value on both sides.
- R10: Word addresses: 0 identifier (REV_ID in bits 7:0, upper bits 0), 1 control, 2 load, 3 trigger, 4 key, 5 status. Read data is registered and valid in the bus cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| tick_clk | input | 1 | Slow counting clock |
| tick_rst | input | 1 | Synchronous active-high reset, slow domain |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| wdt_rst_o | output | 1 | Watchdog reset pulse, slow domain |

## Verification
The rollover period is swept over three load values and five control settings: prescaler off, ratios 0, 1 and 2, and a ratio written while the prescaler is off. Each measured interval is compared with the arithmetic product of the step count and the division factor. This separates a wrong load path from a wrong divider, and it catches a ratio field that is honoured without its enable bit. Trigger writes that keep changing are set against repeated writes of one value: the first must hold the reset off for longer than a full period, and the second must let it fire. Key patterns cover the correct pairs, a broken start pair, a lone second key and a broken stop pair. A double write to the load register, followed by a check of the resulting period, tells a dropped write from an overwritten one.

// File: rtl/kwdt_pkg.sv
`timescale 1ns/1ps
package kwdt_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_REV  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] A_LOAD = 3'd2;
  localparam logic [ADDR_W-1:0] A_TRIG = 3'd3;
  localparam logic [ADDR_W-1:0] A_KEY  = 3'd4;
  localparam logic [ADDR_W-1:0] A_PEND = 3'd5;

  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] KEY_ON1  = 16'hBBBB;
  localparam logic [KEY_W-1:0] KEY_ON2  = 16'h4444;
  localparam logic [KEY_W-1:0] KEY_OFF1 = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_OFF2 = 16'h5555;

  // control field: stored as {pre_en, ratio[2:0]} taken from bus bits 5:2
  localparam int PTV_W  = 3;
  localparam int CTL_W  = PTV_W + 1;
  localparam int CTL_LO = 2;
  localparam int PRE_W  = (2 ** PTV_W) - 1;

  typedef enum logic [1:0] {K_IDLE, K_ON, K_OFF} key_st_e;
endpackage

// File: rtl/kwdt_xfer.sv
`timescale 1ns/1ps
module kwdt_xfer #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         b_clk,
  input  logic         b_rst,
  input  logic         s_clk,
  input  logic         s_rst,
  input  logic         b_wr,
  input  logic [W-1:0] b_wdata,
  output logic         b_pend,
  output logic [W-1:0] b_hold,
  output logic         s_apply,
  output logic [W-1:0] s_data
);
  logic req_tog, ack_m, ack_s;
  logic req_m, req_s, s_seen;

  // bus side: capture data, flip request toggle, watch acknowledge
  always_ff @(posedge b_clk) begin
    if (b_rst) begin
      req_tog <= 1'b0;
      b_hold  <= RST_VAL;
      ack_m   <= 1'b0;
      ack_s   <= 1'b0;
    end else begin
      ack_m <= s_seen;
      ack_s <= ack_m;
      if (b_wr) begin
        b_hold  <= b_wdata;
        req_tog <= ~req_tog;
      end
    end
  end

  assign b_pend = req_tog ^ ack_s;

  // slow side: synchronise the toggle and emit one apply pulse per flip
  always_ff @(posedge s_clk) begin
    if (s_rst) begin
      req_m  <= 1'b0;
      req_s  <= 1'b0;
      s_seen <= 1'b0;
    end else begin
      req_m  <= req_tog;
      req_s  <= req_m;
      s_seen <= req_s;
    end
  end

  assign s_apply = req_s ^ s_seen;
  assign s_data  = b_hold;   // frozen while the crossing is pending

  p_hold_frozen_r9: assert property (@(posedge b_clk) disable iff (b_rst)
    $past(b_pend) |-> $stable(b_hold));

  p_apply_single_r8: assert property (@(posedge s_clk) disable iff (s_rst)
    s_apply |=> !s_apply);
endmodule

// File: rtl/kwdt_regs.sv
`timescale 1ns/1ps
module kwdt_regs
  import kwdt_pkg::*;
#(
  parameter int DW = 32,
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] LOAD_RST = '1,
  parameter logic [7:0] REV_ID = 8'h21
) (
  input  logic              b_clk,
  input  logic              b_rst,
  input  logic              s_clk,
  input  logic              s_rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              s_ctl_apply,
  output logic [CTL_W-1:0]  s_ctl,
  output logic              s_ld_apply,
  output logic [CNT_W-1:0]  s_ld,
  output logic              s_tr_apply,
  output logic [DW-1:0]     s_tr,
  output logic              s_key_apply,
  output logic [KEY_W-1:0]  s_key
);
  logic pend_ctl, pend_ld, pend_tr, pend_key;
  logic wr_ctl, wr_ld, wr_tr, wr_key;
  logic [CTL_W-1:0] ctl_hold;
  logic [CNT_W-1:0] ld_hold;
  logic [DW-1:0]    tr_hold;
  logic [KEY_W-1:0] key_hold;
  logic [DW-1:0]    pend_word;

  // accepted writes: address match and no crossing in flight
  assign wr_ctl = bus_wr && (bus_addr == A_CTRL) && !pend_ctl;
  assign wr_ld  = bus_wr && (bus_addr == A_LOAD) && !pend_ld;
  assign wr_tr  = bus_wr && (bus_addr == A_TRIG) && !pend_tr;
  assign wr_key = bus_wr && (bus_addr == A_KEY)  && !pend_key;

  kwdt_xfer #(.W(CTL_W), .RST_VAL('0)) u_ctl (
    .b_clk(b_clk), .b_rst(b_rst), .s_clk(s_clk), .s_rst(s_rst),
    .b_wr(wr_ctl), .b_wdata(bus_wdata[CTL_LO +: CTL_W]),
    .b_pend(pend_ctl), .b_hold(ctl_hold),
    .s_apply(s_ctl_apply), .s_data(s_ctl));

  kwdt_xfer #(.W(CNT_W), .RST_VAL(LOAD_RST)) u_ld (
    .b_clk(b_clk), .b_rst(b_rst), .s_clk(s_clk), .s_rst(s_rst),
    .b_wr(wr_ld), .b_wdata(bus_wdata[CNT_W-1:0]),
    .b_pend(pend_ld), .b_hold(ld_hold),
    .s_apply(s_ld_apply), .s_data(s_ld));

  kwdt_xfer #(.W(DW), .RST_VAL('0)) u_tr (
    .b_clk(b_clk), .b_rst(b_rst), .s_clk(s_clk), .s_rst(s_rst),
    .b_wr(wr_tr), .b_wdata(bus_wdata),
    .b_pend(pend_tr), .b_hold(tr_hold),
    .s_apply(s_tr_apply), .s_data(s_tr));

  kwdt_xfer #(.W(KEY_W), .RST_VAL('0)) u_key (
    .b_clk(b_clk), .b_rst(b_rst), .s_clk(s_clk), .s_rst(s_rst),
    .b_wr(wr_key), .b_wdata(bus_wdata[KEY_W-1:0]),
    .b_pend(pend_key), .b_hold(key_hold),
    .s_apply(s_key_apply), .s_data(s_key));

  assign pend_word = DW'({pend_key, pend_tr, pend_ld, 1'b0, pend_ctl});

  always_ff @(posedge b_clk) begin
    if (b_rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_REV:   bus_rdata <= DW'(REV_ID);
        A_CTRL:  bus_rdata <= DW'({ctl_hold, 2'b00});
        A_LOAD:  bus_rdata <= DW'(ld_hold);
        A_TRIG:  bus_rdata <= tr_hold;
        A_KEY:   bus_rdata <= DW'(key_hold);
        A_PEND:  bus_rdata <= pend_word;
        default: bus_rdata <= '0;
      endcase
    end
  end

  p_block_pending_r9: assert property (@(posedge b_clk) disable iff (b_rst)
    (bus_wr && (bus_addr == A_LOAD) && pend_ld) |=> $stable(ld_hold));

  p_pend_after_write_r8: assert property (@(posedge b_clk) disable iff (b_rst)
    (bus_wr && (bus_addr == A_KEY) && !pend_key) |=> pend_key);
endmodule

// File: rtl/kwdt_core.sv
`timescale 1ns/1ps
module kwdt_core
  import kwdt_pkg::*;
#(
  parameter int DW = 32,
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] LOAD_RST = '1,
  parameter int RST_CYC = 4
) (
  input  logic             s_clk,
  input  logic             s_rst,
  input  logic             ctl_apply,
  input  logic [CTL_W-1:0] ctl_val,
  input  logic             ld_apply,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             tr_apply,
  input  logic [DW-1:0]    tr_val,
  input  logic             key_apply,
  input  logic [KEY_W-1:0] key_val,
  output logic             wdt_rst_o
);
  localparam int RL_W = $clog2(RST_CYC + 1);

  logic             pre_en;
  logic [PTV_W-1:0] ptv;
  logic [CNT_W-1:0] ld_q, cnt;
  logic [DW-1:0]    trig_q;
  logic [PRE_W-1:0] pre_cnt, pre_lim;
  logic [RL_W-1:0]  rst_left;
  logic             run, tick, wrap, reload_evt, fire;
  key_st_e          kst;

  // configuration registers in the slow domain
  always_ff @(posedge s_clk) begin
    if (s_rst) begin
      pre_en <= 1'b0;
      ptv    <= '0;
      ld_q   <= LOAD_RST;
      trig_q <= '0;
    end else begin
      if (ctl_apply) {pre_en, ptv} <= ctl_val;
      if (ld_apply)  ld_q <= ld_val;
      if (tr_apply)  trig_q <= tr_val;
    end
  end

  // two-word key sequencer
  always_ff @(posedge s_clk) begin
    if (s_rst) begin
      kst <= K_IDLE;
      run <= 1'b1;
    end else if (key_apply) begin
      case (key_val)
        KEY_ON1:  kst <= K_ON;
        KEY_OFF1: kst <= K_OFF;
        KEY_ON2: begin
          if (kst == K_ON) run <= 1'b1;
          kst <= K_IDLE;
        end
        KEY_OFF2: begin
          if (kst == K_OFF) run <= 1'b0;
          kst <= K_IDLE;
        end
        default:  kst <= K_IDLE;
      endcase
    end
  end

  // prescaler and counter
  assign pre_lim    = (PRE_W'(1) << ptv) - PRE_W'(1);
  assign tick       = run && (!pre_en || (pre_cnt == pre_lim));
  assign wrap       = tick && (cnt == '1);
  assign reload_evt = tr_apply && (tr_val != trig_q);
  assign fire       = wrap && !reload_evt;

  always_ff @(posedge s_clk) begin
    if (s_rst) begin
      pre_cnt <= '0;
      cnt     <= LOAD_RST;
    end else begin
      if (reload_evt || ctl_apply)
        pre_cnt <= '0;
      else if (run && pre_en)
        pre_cnt <= (pre_cnt == pre_lim) ? '0 : pre_cnt + PRE_W'(1);

      if (reload_evt || wrap)
        cnt <= ld_q;
      else if (tick)
        cnt <= cnt + CNT_W'(1);
    end
  end

  // reset pulse stretcher
  always_ff @(posedge s_clk) begin
    if (s_rst) begin
      wdt_rst_o <= 1'b0;
      rst_left  <= '0;
    end else if (fire) begin
      wdt_rst_o <= 1'b1;
      rst_left  <= RL_W'(RST_CYC - 1);
    end else if (rst_left != '0) begin
      rst_left  <= rst_left - RL_W'(1);
    end else begin
      wdt_rst_o <= 1'b0;
    end
  end

  p_wrap_loads_r4: assert property (@(posedge s_clk) disable iff (s_rst)
    $rose(wdt_rst_o) |-> (cnt == $past(ld_q)));

  p_start_key_r2: assert property (@(posedge s_clk) disable iff (s_rst)
    $rose(run) |-> ($past(key_apply) && ($past(key_val) == KEY_ON2) && ($past(kst) == K_ON)));

  p_stop_key_r3: assert property (@(posedge s_clk) disable iff (s_rst)
    $fell(run) |-> ($past(key_apply) && ($past(key_val) == KEY_OFF2) && ($past(kst) == K_OFF)));

  p_hold_when_off_r2: assert property (@(posedge s_clk) disable iff (s_rst)
    (!run && !reload_evt) |=> $stable(cnt));

  p_pulse_bound_r7: assert property (@(posedge s_clk) disable iff (s_rst)
    wdt_rst_o |-> (rst_left < RL_W'(RST_CYC)));
endmodule

// File: rtl/kwdt_top.sv
`timescale 1ns/1ps
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int DW = 32,
  parameter int CNT_W = 32,
  parameter int LOAD_GAP = 32767,
  parameter int RST_CYC = 4,
  parameter logic [7:0] REV_ID = 8'h21
) (
  input  logic              bus_clk,
  input  logic              bus_rst,
  input  logic              tick_clk,
  input  logic              tick_rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              wdt_rst_o
);
  localparam logic [CNT_W-1:0] LOAD_RST = ~CNT_W'(LOAD_GAP);

  logic             ctl_apply, ld_apply, tr_apply, key_apply;
  logic [CTL_W-1:0] ctl_val;
  logic [CNT_W-1:0] ld_val;
  logic [DW-1:0]    tr_val;
  logic [KEY_W-1:0] key_val;

  kwdt_regs #(.DW(DW), .CNT_W(CNT_W), .LOAD_RST(LOAD_RST), .REV_ID(REV_ID)) u_regs (
    .b_clk(bus_clk), .b_rst(bus_rst), .s_clk(tick_clk), .s_rst(tick_rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .s_ctl_apply(ctl_apply), .s_ctl(ctl_val),
    .s_ld_apply(ld_apply), .s_ld(ld_val),
    .s_tr_apply(tr_apply), .s_tr(tr_val),
    .s_key_apply(key_apply), .s_key(key_val));

  kwdt_core #(.DW(DW), .CNT_W(CNT_W), .LOAD_RST(LOAD_RST), .RST_CYC(RST_CYC)) u_core (
    .s_clk(tick_clk), .s_rst(tick_rst),
    .ctl_apply(ctl_apply), .ctl_val(ctl_val),
    .ld_apply(ld_apply), .ld_val(ld_val),
    .tr_apply(tr_apply), .tr_val(tr_val),
    .key_apply(key_apply), .key_val(key_val),
    .wdt_rst_o(wdt_rst_o));
endmodule

// File: tb/sim_kwdt_top.sv
`timescale 1ns/1ps
module sim_kwdt_top;
  localparam int DW = 32;
  localparam int CNT_W = 8;
  localparam int LOAD_GAP = 15;
  localparam int RST_CYC = 3;
  localparam int MOD = 2 ** CNT_W;

  logic bclk = 1'b0, tclk = 1'b0;
  logic brst = 1'b1, trst = 1'b1;
  logic wr = 1'b0, rd = 1'b0;
  logic [2:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic wdt;

  int nchk = 0, nerr = 0;
  int slow_n = 0, rise_cnt = 0, last_rise = 0, prev_rise = 0;
  int hi_run = 0, last_width = 0;
  logic prev_wdt = 1'b0;
  bit done = 0;

  always #5  bclk = ~bclk;
  always #20 tclk = ~tclk;

  kwdt_top #(.DW(DW), .CNT_W(CNT_W), .LOAD_GAP(LOAD_GAP), .RST_CYC(RST_CYC),
             .REV_ID(8'h5A)) u0 (
    .bus_clk(bclk), .bus_rst(brst), .tick_clk(tclk), .tick_rst(trst),
    .bus_wr(wr), .bus_rd(rd), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .wdt_rst_o(wdt));

  // pulse recorder in slow-clock units
  always @(posedge tclk) begin
    if (trst) begin
      prev_wdt = 1'b0;
    end else begin
      if (wdt && !prev_wdt) begin
        rise_cnt  = rise_cnt + 1;
        prev_rise = last_rise;
        last_rise = slow_n;
        hi_run    = 1;
      end else if (wdt) begin
        hi_run = hi_run + 1;
      end
      if (!wdt && prev_wdt) last_width = hi_run;
      prev_wdt = wdt;
      slow_n   = slow_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge bclk); rd = 1'b1; addr = a;
    @(negedge bclk); rd = 1'b0; d = rdata;
  endtask

  task automatic raw_write(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge bclk); wr = 1'b1; addr = a; wdata = d;
    @(negedge bclk); wr = 1'b0;
  endtask

  function automatic int pbit(input logic [2:0] a);
    case (a)
      3'd1: return 0;
      3'd2: return 2;
      3'd3: return 3;
      default: return 4;
    endcase
  endfunction

  task automatic wait_free(input int b);
    logic [DW-1:0] s;
    bus_read(3'd5, s);
    while (s[b]) bus_read(3'd5, s);
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [DW-1:0] d);
    wait_free(pbit(a));
    raw_write(a, d);
    wait_free(pbit(a));
  endtask

  task automatic wait_rises(input int n);
    int start;
    start = rise_cnt;
    while (rise_cnt < start + n) @(posedge tclk);
  endtask

  task automatic wait_slow(input int n);
    for (int i = 0; i < n; i++) @(posedge tclk);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    int base, per, div;
    int loads [3];
    loads[0] = 'hF0; loads[1] = 'hD0; loads[2] = 'hA0;

    repeat (12) @(negedge bclk);
    brst = 1'b0; trst = 1'b0;

    // R1 / R10 reset state and address map
    bus_read(3'd5, d); chk(d == 0, "R1", "status after reset", d, 0);
    bus_read(3'd0, d); chk(d == 32'h5A, "R10", "identifier", d, 'h5A);
    bus_read(3'd2, d); chk(d == 32'hF0, "R1", "load after reset", d, 'hF0);
    bus_read(3'd1, d); chk(d == 0, "R1", "control after reset", d, 0);
    bus_read(3'd3, d); chk(d == 0, "R1", "trigger after reset", d, 0);

    // R1 running at reset, R4 default period, R7 width
    wait_rises(2);
    chk(last_rise - prev_rise == MOD - 'hF0, "R4", "default period",
        last_rise - prev_rise, MOD - 'hF0);
    wait_slow(RST_CYC + 2);
    chk(last_width == RST_CYC, "R7", "pulse width", last_width, RST_CYC);

    // R8 per-register pending bits
    raw_write(3'd2, 32'hF0);
    bus_read(3'd5, d); chk(d == 32'h04, "R8", "load pending", d, 4);
    wait_free(2);
    bus_read(3'd5, d); chk(d == 0, "R8", "load pending cleared", d, 0);
    raw_write(3'd1, 32'h0);
    bus_read(3'd5, d); chk(d == 32'h01, "R8", "control pending", d, 1);
    wait_free(0);
    raw_write(3'd3, 32'h77);
    bus_read(3'd5, d); chk(d == 32'h08, "R8", "trigger pending", d, 8);
    wait_free(3);
    raw_write(3'd4, 32'h0);
    bus_read(3'd5, d); chk(d == 32'h10, "R8", "key pending", d, 16);
    wait_free(4);

    // R9 second write while pending is dropped
    raw_write(3'd2, 32'hD0);
    raw_write(3'd2, 32'h10);
    wait_free(2);
    bus_read(3'd2, d); chk(d == 32'hD0, "R9", "load readback", d, 'hD0);
    wait_rises(2);
    chk(last_rise - prev_rise == MOD - 'hD0, "R9", "period uses first write",
        last_rise - prev_rise, MOD - 'hD0);

    // R4 / R5 sweep: load x prescaler mode
    foreach (loads[li]) begin
      for (int m = 0; m < 5; m++) begin
        logic [DW-1:0] c;
        if (m == 0)      begin c = 0; div = 1; end
        else if (m == 4) begin c = 32'h08; div = 1; end
        else             begin c = 32'h20 | ((m - 1) << 2); div = 1 << (m - 1); end
        bus_write(3'd2, loads[li]);
        bus_write(3'd1, c);
        wait_rises(2);
        per = (MOD - loads[li]) * div;
        chk(last_rise - prev_rise == per, (m == 0) ? "R4" : "R5",
            $sformatf("period load=%0h ctrl=%0h", loads[li], c),
            last_rise - prev_rise, per);
      end
    end
    bus_write(3'd1, 32'h0);
    bus_write(3'd2, 32'h0);

    // R6 changing trigger keeps reset off, repeated value does not
    wait_rises(1);
    base = rise_cnt;
    for (int k = 0; k < 8; k++) begin
      bus_write(3'd3, 32'h100 + k);
      wait_slow(40);
    end
    chk(rise_cnt == base, "R6", "changing trigger rises", rise_cnt - base, 0);
    base = rise_cnt;
    for (int k = 0; k < 10; k++) begin
      bus_write(3'd3, 32'h107);
      wait_slow(40);
    end
    chk(rise_cnt > base, "R6", "same trigger rises", rise_cnt - base, 1);

    // R3 stop pair
    bus_write(3'd4, 32'hAAAA);
    bus_write(3'd4, 32'h5555);
    wait_slow(4);
    base = rise_cnt;
    wait_slow(400);
    chk(rise_cnt == base, "R3", "stopped rises", rise_cnt - base, 0);

    // R2 broken start pair and lone second key
    bus_write(3'd4, 32'hBBBB);
    bus_write(3'd4, 32'h1234);
    bus_write(3'd4, 32'h4444);
    base = rise_cnt;
    wait_slow(400);
    chk(rise_cnt == base, "R2", "broken start rises", rise_cnt - base, 0);
    bus_write(3'd4, 32'h4444);
    wait_slow(400);
    chk(rise_cnt == base, "R2", "lone key rises", rise_cnt - base, 0);

    // R2 correct start pair
    bus_write(3'd4, 32'hBBBB);
    bus_write(3'd4, 32'h4444);
    base = rise_cnt;
    wait_slow(400);
    chk(rise_cnt > base, "R2", "started rises", rise_cnt - base, 1);

    // R3 broken stop pair keeps running
    bus_write(3'd4, 32'hAAAA);
    bus_write(3'd4, 32'h1111);
    bus_write(3'd4, 32'h5555);
    base = rise_cnt;
    wait_slow(400);
    chk(rise_cnt > base, "R3", "broken stop rises", rise_cnt - base, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule